// File: doc/BRIEF.md
# Handshaked Sequential Adder

This block adds two 16-bit operands under a request/acknowledge handshake. A master raises a request. The block answers by dropping its acknowledge, and it raises the acknowledge again once the sum is ready. The design has two parts. The data part holds two operand registers, an adder and a result register. The control part is a three-state one-hot sequencer with an idle state, a capture state and a compute state, and each state lasts one clock cycle.

When the idle state sees the request high, the sequencer moves to capture. In the capture cycle the operand buses are latched into the operand registers at the closing clock edge. The compute state then writes the 16-bit sum, with the carry discarded, into the result register and returns to idle without condition. The acknowledge is high exactly while the sequencer is idle. The result stays valid until the next completion overwrites it. If the request is still high when the block returns to idle, the next transaction starts at once, so one transaction takes three cycles.

Top module: `hs_adder`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, ack_o is 1 and sum_o is 0. The reset is asynchronous and active low.
- R2: While the block is idle (ack_o = 1) and req_i is low, ack_o stays 1 on every edge.
- R3: A clock edge that samples req_i = 1 while ack_o = 1 drives ack_o to 0 in the following cycle.
- R4: The operands are the values on opnd_x_i and opnd_y_i in the first cycle with ack_o = 0 (the capture cycle). Changes to those inputs after the capture edge do not affect the result.
- R5: ack_o returns to 1 two cycles after it fell. From then on, sum_o equals (X + Y) mod 2^16 for the captured operands, and the carry out is dropped.
- R6: sum_o changes only on the edge where ack_o rises. Operand input changes while the block is idle or busy leave sum_o unchanged.
- R7: If req_i is high when ack_o rises, the next edge starts a new transaction, so back-to-back transactions complete every three cycles.
- R8: Exactly one of the three state flops is set at all times.
- R9: Once a transaction has been accepted, req_i is ignored: capture always leads to compute, and compute always leads back to idle.
- R10: An asynchronous reset during a transaction aborts it. ack_o returns to 1 and sum_o to 0 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request from the master |
| opnd_x_i | input | 16 | First operand |
| opnd_y_i | input | 16 | Second operand |
| sum_o | output | 16 | Registered sum modulo 2^16 |
| ack_o | output | 1 | Acknowledge, high when idle and the result is valid |

## Verification
Take the edge that samples the request as edge 0. ack_o is low in the cycle after edge 0 and high again after edge 2. The new sum appears on edge 2, and operands are taken on edge 1. The bench drives inputs on falling edges and samples at the next falling edge after each of those rising edges. It scrambles the operand buses right after edge 1 to prove that the operands were captured on that edge. A request held high is checked to re-enter capture on edge 3. The checker ties each acknowledge fall to its rise exactly two cycles later. It also ties the result on that rise to the operands present one cycle after the fall.

// File: rtl/hs_adder_pkg.sv
package hs_adder_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned N_ST   = 3;

  // one-hot bit positions
  localparam int unsigned ST_IDLE = 0;
  localparam int unsigned ST_CAP  = 1;
  localparam int unsigned ST_CMP  = 2;

  typedef logic [N_ST-1:0] onehot_t;

  localparam onehot_t OH_IDLE = onehot_t'(1) << ST_IDLE;
endpackage

// File: rtl/hs_adder_ctrl.sv
module hs_adder_ctrl
  import hs_adder_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_i,
  output onehot_t state_o,
  output logic    load_ops_o,
  output logic    load_sum_o,
  output logic    ack_o
);
  onehot_t state_q, state_d;

  always_comb begin
    state_d          = '0;
    state_d[ST_IDLE] = (state_q[ST_IDLE] & ~req_i) | state_q[ST_CMP];
    state_d[ST_CAP]  = state_q[ST_IDLE] & req_i;
    state_d[ST_CMP]  = state_q[ST_CAP];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= OH_IDLE;
    else         state_q <= state_d;
  end

  assign state_o    = state_q;
  assign load_ops_o = state_q[ST_CAP];
  assign load_sum_o = state_q[ST_CMP];
  assign ack_o      = state_q[ST_IDLE];
endmodule

// File: rtl/hs_adder_dp.sv
module hs_adder_dp #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_ops_i,
  input  logic         load_sum_i,
  input  logic [W-1:0] opnd_x_i,
  input  logic [W-1:0] opnd_y_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] opa_q, opb_q, sum_q, add_res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opa_q <= '0;
      opb_q <= '0;
    end else if (load_ops_i) begin
      opa_q <= opnd_x_i;
      opb_q <= opnd_y_i;
    end
  end

  // carry out dropped by width truncation
  assign add_res = opa_q + opb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sum_q <= '0;
    else if (load_sum_i) sum_q <= add_res;
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/hs_adder.sv
module hs_adder
  import hs_adder_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_i,
  input  logic [W-1:0] opnd_x_i,
  input  logic [W-1:0] opnd_y_i,
  output logic [W-1:0] sum_o,
  output logic         ack_o
);
  onehot_t state_q;
  logic    load_ops, load_sum;

  hs_adder_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .state_o    (state_q),
    .load_ops_o (load_ops),
    .load_sum_o (load_sum),
    .ack_o      (ack_o)
  );

  hs_adder_dp #(.W(W)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_ops_i (load_ops),
    .load_sum_i (load_sum),
    .opnd_x_i   (opnd_x_i),
    .opnd_y_i   (opnd_y_i),
    .sum_o      (sum_o)
  );
endmodule

// File: rtl/hs_adder_chk.sv
module hs_adder_chk
  import hs_adder_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         req_i,
  input logic [W-1:0] opnd_x_i,
  input logic [W-1:0] opnd_y_i,
  input logic [W-1:0] sum_o,
  input logic         ack_o,
  input onehot_t      state_i
);
  a_r8_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(state_i) == 1);

  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o && !req_i |=> ack_o);

  a_r3_ack_falls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o && req_i |=> !ack_o);

  a_r5_ack_returns: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_o) |=> !ack_o ##1 ack_o);

  a_r5_sum_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_o) |=> ##1 (sum_o == W'($past(opnd_x_i, 2) + $past(opnd_y_i, 2))));

  a_r6_sum_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(ack_o) |-> $stable(sum_o));

  a_r9_cap_to_cmp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i[ST_CAP] |=> state_i[ST_CMP]);

  a_r9_cmp_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i[ST_CMP] |=> state_i[ST_IDLE]);
endmodule

bind hs_adder hs_adder_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .opnd_x_i (opnd_x_i),
  .opnd_y_i (opnd_y_i),
  .sum_o    (sum_o),
  .ack_o    (ack_o),
  .state_i  (state_q)
);

// File: tb/hs_adder_test.sv
`timescale 1ns/1ps
module hs_adder_test;
  localparam int W = 16;
  localparam int NV = 8;
  // {x, y, expected sum}
  localparam logic [3*W-1:0] VEC [NV] = '{
    {16'h0001, 16'h0002, 16'h0003},
    {16'h1234, 16'h4321, 16'h5555},
    {16'hFFFF, 16'h0001, 16'h0000},
    {16'h8000, 16'h8000, 16'h0000},
    {16'hFFFF, 16'hFFFF, 16'hFFFE},
    {16'h0000, 16'h0000, 16'h0000},
    {16'hA5A5, 16'h5A5A, 16'hFFFF},
    {16'h7FFF, 16'h0002, 16'h8001}
  };

  logic clk = 0, rst_n = 0, req = 0;
  logic [W-1:0] x = '0, y = '0, sum;
  logic ack;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  hs_adder uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req),
    .opnd_x_i(x), .opnd_y_i(y), .sum_o(sum), .ack_o(ack)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step; @(posedge clk); @(negedge clk); endtask

  // request, capture, compute; scrambles operands after capture (R4)
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] e);
    req = 1; x = a; y = b;
    step;                                  // accept edge
    chk("R3 ack low after accept", W'(ack), W'(0));
    req = 0;
    step;                                  // capture edge
    x = ~a; y = a ^ b;
    chk("R9 ack low in compute", W'(ack), W'(0));
    step;                                  // compute edge
    chk("R5 ack back high", W'(ack), W'(1));
    chk("R5 R4 sum value", sum, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ack in reset", W'(ack), W'(1));
    chk("R1 sum in reset", sum, '0);
    rst_n = 1;
    step;
    chk("R1 ack after release", W'(ack), W'(1));
    chk("R1 sum after release", sum, '0);

    for (int i = 0; i < NV; i++)
      run_op(VEC[i][3*W-1:2*W], VEC[i][2*W-1:W], VEC[i][W-1:0]);

    // R2/R6: idle with operands moving and no request
    x = 16'h1111; y = 16'h2222;
    step; x = 16'h3333;
    step;
    chk("R2 idle ack", W'(ack), W'(1));
    chk("R6 sum held idle", sum, 16'h8001);

    // R7: request held high, back-to-back
    req = 1; x = 16'h0010; y = 16'h0020;
    step; step; step;
    chk("R7 first done", W'(ack), W'(1));
    chk("R7 first sum", sum, 16'h0030);
    x = 16'h0100; y = 16'h0200;
    step;
    chk("R7 restarted ack low", W'(ack), W'(0));
    chk("R6 sum held busy", sum, 16'h0030);
    req = 0;
    step; step;
    chk("R7 second done", W'(ack), W'(1));
    chk("R7 second sum", sum, 16'h0300);

    // R10: reset mid transaction
    req = 1; x = 16'h0F0F; y = 16'h0101;
    step; req = 0;
    chk("R10 busy before reset", W'(ack), W'(0));
    #2 rst_n = 0; #1;
    chk("R10 ack on reset", W'(ack), W'(1));
    chk("R10 sum on reset", sum, '0);
    @(negedge clk); rst_n = 1;
    step; step;
    chk("R10 stays idle", W'(ack), W'(1));
    run_op(16'h0F0F, 16'h0101, 16'h1010);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule